// File: doc/BRIEF.md
# Rotating Multi-Bank Shared Memory

This block is a shared long-word memory for sixteen equal cores. Storage is split into sixteen independent 32-bit banks. A time-rotated crossbar links each core to exactly one bank on every clock, and the assignment moves on by one bank per clock. There is no arbiter, so no core ever waits behind another. Each core reaches every bank once every sixteen clocks, and any number of cores can transfer data in the same cycles without reducing each other's rate.

A core issues either a single-long access or a block access. A single access waits until the rotation brings round the bank that holds its address, performs the access in that cycle and reports completion one cycle later. A block access starts in the cycle after it is accepted, whatever slot the rotation is in. It touches one bank per clock for sixteen clocks, covering all sixteen longs of an aligned group in rotation order. The core's own buffer sits outside the block. On each block-write beat the block shows the buffer index it is consuming, and the core drives the long for that index on its write data. On each read beat the block returns the long together with its buffer index. A core that keeps requesting block transfers moves sixteen longs every eighteen clocks.

Top module: `hub_rotmem`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the rotation phase is 0: `slot_bank` of core c equals c, and every `done` and `rd_valid` bit is low.
- R2: The rotation phase advances by one, modulo 16, on every clock. In every cycle core c is linked to bank (c + phase) mod 16, shown on its `slot_bank` field, so each bank belongs to exactly one core.
- R3: A request is accepted on a clock edge at which `req` is high and the core is idle, and `we`, `blk`, `addr` and `wdata` are captured at that edge. A single access (`blk`=0) waits until `slot_bank` equals `addr[3:0]` and performs the access in that cycle. A single write stores the captured `wdata` at long address `addr`.
- R4: A block access (`blk`=1) targets the 16-long group `addr[7:4]` and ignores `addr[3:0]`. It runs for the 16 cycles that follow acceptance. In each of those cycles it accesses long address {`addr[7:4]`, `slot_bank`}. A block write stores the live `wdata` of that cycle as buffer index `slot_bank`.
- R5: In the cycle after each read access, `rd_valid` is high, `rd_idx` holds the bank (equal to the buffer index) that was accessed, and `rdata` holds the long stored at that address before that cycle.
- R6: `done` is high for exactly one cycle, the cycle after the final access of a transfer. That cycle coincides with the last `rd_valid` of a read. The core accepts its next request only from the cycle after `done`, so block transfers kept back to back complete every 18 cycles.
- R7: A request that arrives while the core is busy, or in its `done` cycle, is ignored. It changes no memory contents and does not alter the transfer in progress.
- R8: Block transfers issued by all 16 cores at the same edge run at full rate together: all 16 `done` bits rise in the 17th cycle after acceptance and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 16 | Per-core request strobe |
| we | input | 16 | Per-core write select (1 = write) |
| blk | input | 16 | Per-core block-mode select |
| addr | input | 16*8 | Per-core long address; bits [3:0] select the bank |
| wdata | input | 16*32 | Per-core write data; live for block writes, captured for single writes |
| slot_bank | output | 16*4 | Bank currently linked to each core; buffer index of the current block beat |
| done | output | 16 | One-cycle pulse per core when a transfer finishes |
| rd_valid | output | 16 | Per-core read data valid |
| rd_idx | output | 16*4 | Bank or buffer index of the returned long |
| rdata | output | 16*32 | Per-core read data |

## Verification
A phase counter that slips shows on every core's `slot_bank` in the same cycle. A fault in the bank-side owner selection stays hidden until the affected long is read back, when it appears as a wrong `rdata` with a correct `rd_idx`. An error in the transfer state machine shifts `done` and `rd_valid` by whole cycles. It shows as soon as the transfer ends, and the back-to-back period then moves away from 18. A misrouted read path shows one cycle after the access, because the return mux uses the phase of the previous cycle.

// File: rtl/hub_pkg.sv
package hub_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_RUN  = 2'd1,
    PS_FIN  = 2'd2
  } port_state_e;

  // Bank linked to a core for a given rotation phase.
  function automatic int rot_slot(int core, int phase, int n);
    return (core + phase) % n;
  endfunction

  // Core linked to a bank for a given rotation phase.
  function automatic int rot_owner(int bank, int phase, int n);
    return (bank - phase + n) % n;
  endfunction

  // True on the final beat of a block transfer.
  function automatic logic beat_is_last(int beat, int n);
    return beat == n - 1;
  endfunction

endpackage

// File: rtl/hub_bank.sv
module hub_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int WW    = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [WW-1:0] word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  // One port per clock; the read result is registered.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[word] <= wdata;
      else    q         <= mem[word];
    end
  end

endmodule

// File: rtl/hub_core_port.sv
module hub_core_port
  import hub_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int DW    = 32,
  parameter int BW    = 4,
  parameter int WW    = 4,
  localparam int AW   = BW + WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic          blk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] slot,
  output logic          acc,
  output logic          acc_we,
  output logic [WW-1:0] acc_word,
  output logic [DW-1:0] acc_data,
  output logic          done,
  output logic          rd_valid,
  output logic [BW-1:0] rd_idx
);

  port_state_e   st;
  logic          q_we, q_blk;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [BW-1:0] beat;
  logic          last;

  assign acc      = (st == PS_RUN) && (q_blk || (slot == q_addr[BW-1:0]));
  assign last     = q_blk ? beat_is_last(int'(beat), NCORE) : 1'b1;
  assign acc_we   = q_we;
  assign acc_word = q_addr[AW-1:BW];
  assign acc_data = q_blk ? wdata : q_wdata;
  assign done     = (st == PS_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PS_IDLE;
      q_we     <= 1'b0;
      q_blk    <= 1'b0;
      q_addr   <= '0;
      q_wdata  <= '0;
      beat     <= '0;
      rd_valid <= 1'b0;
      rd_idx   <= '0;
    end else begin
      rd_valid <= acc && !q_we;
      rd_idx   <= slot;
      unique case (st)
        PS_IDLE: if (req) begin
          q_we    <= we;
          q_blk   <= blk;
          q_addr  <= addr;
          q_wdata <= wdata;
          beat    <= '0;
          st      <= PS_RUN;
        end
        PS_RUN: if (acc) begin
          beat <= beat + 1'b1;
          if (last) st <= PS_FIN;
        end
        PS_FIN:  st <= PS_IDLE;
        default: st <= PS_IDLE;
      endcase
    end
  end

  // R6: completion lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: completion always follows an access
  p_done_after_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc));

  // R5: every read access returns data on the next cycle
  p_read_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_we) |=> rd_valid);

  // R7: captured command is frozen while busy
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PS_IDLE) |=> ($stable(q_addr) && $stable(q_we) && $stable(q_blk)));

endmodule

// File: rtl/hub_rotmem.sv
module hub_rotmem
  import hub_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int BW   = $clog2(NCORE),
  localparam int WW   = $clog2(DEPTH),
  localparam int AW   = BW + WW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    req,
  input  logic [NCORE-1:0]    we,
  input  logic [NCORE-1:0]    blk,
  input  logic [NCORE*AW-1:0] addr,
  input  logic [NCORE*DW-1:0] wdata,
  output logic [NCORE*BW-1:0] slot_bank,
  output logic [NCORE-1:0]    done,
  output logic [NCORE-1:0]    rd_valid,
  output logic [NCORE*BW-1:0] rd_idx,
  output logic [NCORE*DW-1:0] rdata
);

  logic [BW-1:0]    phase, phase_d;
  logic [BW-1:0]    slot     [NCORE];
  logic [BW-1:0]    owner    [NCORE];
  logic [NCORE-1:0] acc, acc_we;
  logic [WW-1:0]    acc_word [NCORE];
  logic [DW-1:0]    acc_data [NCORE];
  logic [DW-1:0]    bank_q   [NCORE];
  logic [NCORE-1:0] claim    [NCORE];

  // Free-running rotation phase and its one-cycle-late copy for read return.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      phase_d <= '0;
    end else begin
      phase   <= phase + 1'b1;
      phase_d <= phase;
    end
  end

  // R2: phase steps by one every clock after reset
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (phase == BW'($past(phase) + 1'b1)));

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign slot[c] = BW'(rot_slot(c, int'(phase), NCORE));

    hub_core_port #(
      .NCORE(NCORE), .DW(DW), .BW(BW), .WW(WW)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req[c]),
      .we       (we[c]),
      .blk      (blk[c]),
      .addr     (addr[c*AW +: AW]),
      .wdata    (wdata[c*DW +: DW]),
      .slot     (slot[c]),
      .acc      (acc[c]),
      .acc_we   (acc_we[c]),
      .acc_word (acc_word[c]),
      .acc_data (acc_data[c]),
      .done     (done[c]),
      .rd_valid (rd_valid[c]),
      .rd_idx   (rd_idx[c*BW +: BW])
    );

    assign slot_bank[c*BW +: BW] = slot[c];
    assign rdata[c*DW +: DW]     = bank_q[BW'(rot_slot(c, int'(phase_d), NCORE))];
  end

  for (genvar b = 0; b < NCORE; b++) begin : g_bank
    assign owner[b] = BW'(rot_owner(b, int'(phase), NCORE));

    hub_bank #(.DW(DW), .DEPTH(DEPTH), .WW(WW)) u_bank (
      .clk   (clk),
      .en    (acc[owner[b]]),
      .we    (acc_we[owner[b]]),
      .word  (acc_word[owner[b]]),
      .wdata (acc_data[owner[b]]),
      .q     (bank_q[b])
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_claim
      assign claim[b][c] = acc[c] && (slot[c] == BW'(b));
    end

    // R2: no bank is driven by two cores in one cycle
    p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim[b]));

    // R2: a claiming core is the one the bank port selects
    p_owner_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (claim[b] != '0) |-> acc[owner[b]]);
  end

endmodule

// File: tb/tb_hub_rotmem.sv
module tb_hub_rotmem;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int DW = 32;
  localparam int BW = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]    req, we, blk;
  logic [NC*AW-1:0] addr;
  logic [NC*DW-1:0] wdata;
  logic [NC*BW-1:0] slot_bank;
  logic [NC-1:0]    done, rd_valid;
  logic [NC*BW-1:0] rd_idx;
  logic [NC*DW-1:0] rdata;

  hub_rotmem dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .blk(blk), .addr(addr),
    .wdata(wdata), .slot_bank(slot_bank), .done(done), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Stimulus-side state
  int          addr_b [NC];
  logic [31:0] wreg   [NC];
  logic [31:0] wbuf   [NC][NC];
  bit          bufsel [NC];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      addr[c*AW +: AW]  = AW'(addr_b[c]);
      wdata[c*DW +: DW] = bufsel[c] ? wbuf[c][slot_bank[c*BW +: BW]] : wreg[c];
    end
  end

  // Reference model state
  logic [31:0] mem_m [256];
  int          m_phase;
  int          st_m [NC];
  bit          qwe_m [NC], qblk_m [NC];
  int          qaddr_m [NC];
  logic [31:0] qwd_m [NC];
  int          beat_m [NC];
  bit          pv [NC];
  int          pidx [NC];
  logic [31:0] pdat [NC];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit stream_on = 0;
  int last5 = -1, stream_hits = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      for (int c = 0; c < NC; c++) begin
        st_m[c] = 0; pv[c] = 0; beat_m[c] = 0;
      end
    end else begin
      bit          nv [NC];
      int          nidx [NC];
      logic [31:0] ndat [NC];
      bit          wv [NC];
      int          wi [NC];
      logic [31:0] wd [NC];
      cyc++;
      for (int c = 0; c < NC; c++) begin
        chk("R2", 32'(slot_bank[c*BW +: BW]), 32'((c + m_phase) % NC), $sformatf("slot core%0d", c));
        chk("R6", 32'(done[c]), 32'(st_m[c] == 2), $sformatf("done core%0d", c));
        chk("R5", 32'(rd_valid[c]), 32'(pv[c]), $sformatf("rd_valid core%0d", c));
        if (pv[c]) begin
          chk("R5", 32'(rd_idx[c*BW +: BW]), 32'(pidx[c]), $sformatf("rd_idx core%0d", c));
          chk("R4", rdata[c*DW +: DW], pdat[c], $sformatf("rdata core%0d", c));
        end
      end
      if (stream_on && done[5]) begin
        if (last5 >= 0) begin
          chk("R6", 32'(cyc - last5), 32'd18, "back-to-back block period");
          stream_hits++;
        end
        last5 = cyc;
      end
      // advance model by one clock edge
      for (int c = 0; c < NC; c++) begin
        nv[c] = 0; wv[c] = 0; nidx[c] = 0; ndat[c] = '0; wi[c] = 0; wd[c] = '0;
        if (st_m[c] == 1) begin
          int  bank;
          bit  act;
          bank = (c + m_phase) % NC;
          act  = qblk_m[c] || (bank == (qaddr_m[c] & 15));
          if (act) begin
            int idx;
            idx = (qaddr_m[c] & 8'hF0) | bank;
            if (qwe_m[c]) begin
              wv[c] = 1; wi[c] = idx;
              wd[c] = qblk_m[c] ? wbuf[c][bank] : qwd_m[c];
            end else begin
              nv[c] = 1; nidx[c] = bank; ndat[c] = mem_m[idx];
            end
            if (!qblk_m[c] || beat_m[c] == NC - 1) st_m[c] = 2;
            else beat_m[c]++;
          end
        end else if (st_m[c] == 2) begin
          st_m[c] = 0;
        end else if (req[c]) begin
          st_m[c] = 1; beat_m[c] = 0;
          qwe_m[c] = we[c]; qblk_m[c] = blk[c];
          qaddr_m[c] = addr_b[c] & 8'hFF; qwd_m[c] = wreg[c];
        end
      end
      for (int c = 0; c < NC; c++) begin
        if (wv[c]) mem_m[wi[c]] = wd[c];
        pv[c] = nv[c]; pidx[c] = nidx[c]; pdat[c] = ndat[c];
      end
      m_phase = (m_phase + 1) % NC;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fire();
    step(1);
    req = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = '0; we = '0; blk = '0;
    for (int c = 0; c < NC; c++) begin
      addr_b[c] = 0; wreg[c] = '0; bufsel[c] = 0;
      for (int i = 0; i < NC; i++) wbuf[c][i] = {8'hB0 + 8'(c), 8'(i), 16'(c * 97 + i * 13)};
    end
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'(done), 32'd0, "done after reset");
    chk("R1", 32'(rd_valid), 32'd0, "rd_valid after reset");
    for (int c = 0; c < NC; c++)
      chk("R1", 32'(slot_bank[c*BW +: BW]), 32'(c), $sformatf("slot core%0d after reset", c));
    step(1);

    // R3: single writes from every core at once
    for (int c = 0; c < NC; c++) begin
      req[c] = 1; we[c] = 1; blk[c] = 0;
      addr_b[c] = (c << 4) | ((c * 7 + 3) & 15);
      wreg[c] = 32'hA000_0000 + 32'(c * 4099);
    end
    fire();
    step(20);

    // R3/R5: single reads of a neighbour's address
    for (int c = 0; c < NC; c++) begin
      req[c] = 1; we[c] = 0; blk[c] = 0;
      addr_b[c] = (((c + 1) % NC) << 4) | ((((c + 1) % NC) * 7 + 3) & 15);
    end
    fire();
    step(20);

    // R4/R8: block writes from all cores in the same cycle
    for (int c = 0; c < NC; c++) begin
      bufsel[c] = 1; req[c] = 1; we[c] = 1; blk[c] = 1;
      addr_b[c] = (c << 4) | c;
    end
    fire();
    repeat (16) @(negedge clk);
    chk("R8", 32'(done), 32'd0, "done one cycle early");
    @(negedge clk);
    chk("R8", 32'(done), 32'h0000_FFFF, "all cores done together");
    step(3);
    for (int c = 0; c < NC; c++) bufsel[c] = 0;

    // R4/R5: block reads, low address bits ignored
    for (int c = 0; c < NC; c++) begin
      req[c] = 1; we[c] = 0; blk[c] = 1;
      addr_b[c] = ((15 - c) << 4) | ((c * 3) & 15);
    end
    fire();
    step(20);

    // R7: request while busy is ignored
    for (int i = 0; i < NC; i++) wbuf[6][i] = wbuf[6][i] ^ 32'h5A5A_0F0F;
    bufsel[6] = 1; req[6] = 1; we[6] = 1; blk[6] = 1; addr_b[6] = 6 << 4;
    fire();
    step(3);
    req[6] = 1; we[6] = 1; blk[6] = 0; addr_b[6] = (6 << 4) | 2; wreg[6] = 32'hDEAD_BEEF;
    step(4);
    req[6] = 0;
    step(20);
    bufsel[6] = 0;
    req[7] = 1; we[7] = 0; blk[7] = 1; addr_b[7] = 6 << 4;
    req[8] = 1; we[8] = 0; blk[8] = 0; addr_b[8] = (6 << 4) | 2;
    fire();
    step(20);

    // R3/R4: single write and block read of the same group concurrently
    req[0] = 1; we[0] = 1; blk[0] = 0; addr_b[0] = 8'h13; wreg[0] = 32'h1357_9BDF;
    req[1] = 1; we[1] = 0; blk[1] = 1; addr_b[1] = 8'h10;
    fire();
    step(20);
    req[2] = 1; we[2] = 0; blk[2] = 0; addr_b[2] = 8'h13;
    fire();
    step(20);

    // R6/R7: back-to-back block reads, address changed mid-stream
    stream_on = 1;
    req[5] = 1; we[5] = 0; blk[5] = 1; addr_b[5] = 2 << 4;
    step(10);
    addr_b[5] = (9 << 4) | 5;
    step(62);
    req[5] = 0;
    step(20);
    stream_on = 0;
    chk("R6", 32'(stream_hits >= 3), 32'd1, "back-to-back periods observed");

    finish_run();
  end

endmodule